// File: doc/BRIEF.md
# Paired-Channel ADC Conversion Sequencer

This block sequences the conversion of two analog inputs through one shared successive-approximation converter. The even input has its own dedicated sample-and-hold, and the odd input uses a shared one. After a trigger, the block runs the dedicated sample window and times the shared sample strobe. It then issues two convert requests, one per channel, in a configurable order. It waits for the converter's done signal after each request, formats the 10-bit result into a 16-bit word and writes it to the result register for that channel. It pulses an interrupt after either the first or the second conversion.

Software writes a 7-bit control word. The field positions are bit 0 enable, bit 1 software trigger, bit 2 fractional format, bit 3 early interrupt, bit 4 odd-first order, bit 5 sequential shared sampling and bit 6 free-running dedicated sampling. Clearing enable returns the sequencer to idle at once.

The sequencer has six states:
- IDLE waits for a trigger.
- DSMP extends the dedicated sample window.
- REQ1 and REQ2 each issue a one-cycle convert request.
- WAIT1 and WAIT2 each wait for done.

The transitions are:
- IDLE to DSMP, or straight to REQ1, on an accepted trigger.
- DSMP to REQ1 when the window ends.
- REQ1 to WAIT1, and REQ2 to WAIT2, unconditionally.
- WAIT1 to REQ2 on done.
- WAIT2 to IDLE on done.
- Any state to IDLE when enable is 0.

Top module: `pair_adc_seq`

## Requirements
- R1: After reset every control field is 0 (module off, integer format, even first). All strobes, valid flags, the interrupt and both results are 0. A hardware trigger while the module is off starts nothing.
- R2: With order bit 4 = 0, the first request carries conv_ch = 0 (even) and the second carries conv_ch = 1 (odd). With bit 4 = 1, the order is reversed.
- R3: With sequential sampling (bit 5 = 1), shr_sample pulses once per pair. It pulses in the cycle of the convert request for the odd channel: the second request when bit 4 = 0, the first when bit 4 = 1.
- R4: With bit 5 = 0, shr_sample pulses once per pair, in the cycle the trigger is accepted, and in no request cycle.
- R5: With bit 6 = 0, ded_sample is high for exactly two cycles per pair: the trigger-accept cycle and the next cycle. The first request follows right after those two cycles. ded_sample is low while the block is idle.
- R6: With bit 6 = 1 and the module enabled, ded_sample is high throughout idle. It goes low in the same cycle a trigger is seen.
- R7: With bit 3 = 1, irq pulses together with the first result's valid. With bit 3 = 0, irq pulses together with the second result's valid. irq lasts one cycle.
- R8: Integer format (bit 2 = 0) gives {6'b0, data}. Fractional format (bit 2 = 1) gives {data, 6'b0}.
- R9: The software trigger fires on a 0-to-1 change of bit 1 only. Holding the bit at 1 starts exactly one pair.
- R10: While enable is 1, writes leave bits 2 to 6 unchanged. Only enable and the software trigger bit take the written value.
- R11: A trigger that arrives while a pair is in progress is ignored and is not queued. Each pair issues exactly two requests.
- R12: Each result appears one cycle after its done, in even_res or odd_res, with a one-cycle even_vld or odd_vld. The two valid flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (also the converter clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 7 | Control word written when ctrl_we is high |
| hw_trig | input | 1 | Hardware trigger pulse |
| conv_done | input | 1 | Converter finished the current request |
| conv_data | input | 10 | Converter result, valid with conv_done |
| conv_req | output | 1 | One-cycle convert request |
| conv_ch | output | 1 | Channel of the request: 0 even, 1 odd |
| ded_sample | output | 1 | Dedicated sample-and-hold sampling |
| shr_sample | output | 1 | Shared sample-and-hold sample strobe |
| even_res | output | 16 | Formatted even-channel result |
| even_vld | output | 1 | even_res updated this cycle |
| odd_res | output | 16 | Formatted odd-channel result |
| odd_vld | output | 1 | odd_res updated this cycle |
| irq | output | 1 | Interrupt pulse |

## Verification
A wrong state or next-state choice shows at the ports within one request. If the channel order is wrong, the results land in the wrong register at the first valid. If the sample strobe sits in the wrong cycle, shr_sample appears beside the wrong request or outside the trigger cycle. A miscounted dedicated window changes the length of the ded_sample pulse before the first request. A busy sequencer that wrongly re-accepts a trigger issues a third request and an unexpected result within a dozen cycles.

// File: rtl/pas_pkg.sv
package pas_pkg;
    // bit 0 enable ... bit 6 free-running dedicated sampling
    typedef struct packed {
        logic async_samp;
        logic seq_samp;
        logic odd_first;
        logic early_irq;
        logic frac_fmt;
        logic sw_trig;
        logic enable;
    } pas_ctrl_t;

    localparam int CTRL_W = $bits(pas_ctrl_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DSMP,
        ST_REQ1,
        ST_WAIT1,
        ST_REQ2,
        ST_WAIT2
    } pas_state_e;
endpackage

// File: rtl/pas_ctrl_reg.sv
module pas_ctrl_reg
    import pas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output pas_ctrl_t         ctrl,
    output logic              sw_edge
);
    pas_ctrl_t wr_v;
    logic      sw_prev;

    assign wr_v = pas_ctrl_t'(wr_data);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            sw_prev <= 1'b0;
        end else begin
            sw_prev <= ctrl.sw_trig;
            if (wr_en) begin
                ctrl.enable  <= wr_v.enable;
                ctrl.sw_trig <= wr_v.sw_trig;
                if (!ctrl.enable) begin
                    ctrl.frac_fmt   <= wr_v.frac_fmt;
                    ctrl.early_irq  <= wr_v.early_irq;
                    ctrl.odd_first  <= wr_v.odd_first;
                    ctrl.seq_samp   <= wr_v.seq_samp;
                    ctrl.async_samp <= wr_v.async_samp;
                end
            end
        end
    end

    assign sw_edge = ctrl.sw_trig & ~sw_prev;

    // R10: configuration fields frozen while enabled
    p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.enable |=> $stable({ctrl.async_samp, ctrl.seq_samp, ctrl.odd_first,
                                 ctrl.early_irq, ctrl.frac_fmt}));
endmodule

// File: rtl/pas_fmt.sv
module pas_fmt #(
    parameter int RES_W = 10,
    parameter int OUT_W = 16
) (
    input  logic             frac,
    input  logic [RES_W-1:0] din,
    output logic [OUT_W-1:0] dout
);
    localparam int PAD = OUT_W - RES_W;

    always_comb begin
        if (frac) dout = {din, {PAD{1'b0}}};
        else      dout = {{PAD{1'b0}}, din};
    end
endmodule

// File: rtl/pas_seq_fsm.sv
module pas_seq_fsm
    import pas_pkg::*;
#(
    parameter int DSMP_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pas_ctrl_t ctrl,
    input  logic      trig,
    input  logic      conv_done,
    output logic      conv_req,
    output logic      conv_ch,
    output logic      ded_sample,
    output logic      shr_sample,
    output logic      cap_even,
    output logic      cap_odd,
    output logic      irq_set
);
    localparam int CNT_W = (DSMP_CYC > 2) ? $clog2(DSMP_CYC) : 1;

    pas_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic accept, done_now;

    assign accept   = (state == ST_IDLE) && ctrl.enable && trig;
    assign done_now = ((state == ST_WAIT1) || (state == ST_WAIT2)) && conv_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (!ctrl.enable) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    if (ctrl.async_samp || DSMP_CYC < 2) begin
                        state_nx = ST_REQ1;
                    end else begin
                        state_nx = ST_DSMP;
                        cnt_nx   = CNT_W'(DSMP_CYC - 2);
                    end
                end
                ST_DSMP: begin
                    if (cnt == '0) state_nx = ST_REQ1;
                    else           cnt_nx   = cnt - 1'b1;
                end
                ST_REQ1:  state_nx = ST_WAIT1;
                ST_WAIT1: if (conv_done) state_nx = ST_REQ2;
                ST_REQ2:  state_nx = ST_WAIT2;
                ST_WAIT2: if (conv_done) state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        conv_req   = 1'b0;
        conv_ch    = 1'b0;
        ded_sample = 1'b0;
        shr_sample = 1'b0;
        irq_set    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ded_sample = ctrl.enable && (ctrl.async_samp ? !trig : trig);
                shr_sample = accept && !ctrl.seq_samp;
            end
            ST_DSMP: ded_sample = 1'b1;
            ST_REQ1: begin
                conv_req   = 1'b1;
                conv_ch    = ctrl.odd_first;
                shr_sample = ctrl.seq_samp && ctrl.odd_first;
            end
            ST_WAIT1: begin
                conv_ch = ctrl.odd_first;
                irq_set = done_now && ctrl.early_irq;
            end
            ST_REQ2: begin
                conv_req   = 1'b1;
                conv_ch    = !ctrl.odd_first;
                shr_sample = ctrl.seq_samp && !ctrl.odd_first;
            end
            ST_WAIT2: begin
                conv_ch = !ctrl.odd_first;
                irq_set = done_now && !ctrl.early_irq;
            end
            default: ;
        endcase
    end

    assign cap_even = done_now && !conv_ch;
    assign cap_odd  = done_now && conv_ch;

    // R5: in clocked-window mode the first request directly follows sampling
    p_ded_before_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ1 && !ctrl.async_samp) |-> $past(ded_sample));

    // R11: a busy sequencer does not leave its wait state except on done
    p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT2 && !conv_done && ctrl.enable) |=> (state == ST_WAIT2));

    // R3: shared strobe in a request cycle only in sequential mode
    p_shr_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shr_sample && conv_req) |-> ctrl.seq_samp);
endmodule

// File: rtl/pair_adc_seq.sv
module pair_adc_seq
    import pas_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int OUT_W    = 16,
    parameter int DSMP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              hw_trig,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    output logic              conv_req,
    output logic              conv_ch,
    output logic              ded_sample,
    output logic              shr_sample,
    output logic [OUT_W-1:0]  even_res,
    output logic              even_vld,
    output logic [OUT_W-1:0]  odd_res,
    output logic              odd_vld,
    output logic              irq
);
    pas_ctrl_t        ctrl;
    logic             sw_edge, trig;
    logic             cap_even, cap_odd, irq_set;
    logic [OUT_W-1:0] fmt_q;

    pas_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_we),
        .wr_data (ctrl_wdata),
        .ctrl    (ctrl),
        .sw_edge (sw_edge)
    );

    assign trig = hw_trig | sw_edge;

    pas_seq_fsm #(.DSMP_CYC(DSMP_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .trig       (trig),
        .conv_done  (conv_done),
        .conv_req   (conv_req),
        .conv_ch    (conv_ch),
        .ded_sample (ded_sample),
        .shr_sample (shr_sample),
        .cap_even   (cap_even),
        .cap_odd    (cap_odd),
        .irq_set    (irq_set)
    );

    pas_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
        .frac (ctrl.frac_fmt),
        .din  (conv_data),
        .dout (fmt_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_res <= '0;
            odd_res  <= '0;
            even_vld <= 1'b0;
            odd_vld  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            even_vld <= cap_even;
            odd_vld  <= cap_odd;
            irq      <= irq_set;
            if (cap_even) even_res <= fmt_q;
            if (cap_odd)  odd_res  <= fmt_q;
        end
    end

    // R7: interrupt is a single-cycle pulse
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: interrupt only alongside a result
    p_irq_with_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (even_vld || odd_vld));

    // R12: valid flags exclusive
    p_vld_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(even_vld && odd_vld));
endmodule

// File: tb/pair_adc_seq_test.sv
module pair_adc_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [6:0]  ctrl_wdata = '0;
    logic        hw_trig = 1'b0;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic        conv_req, conv_ch, ded_sample, shr_sample;
    logic [15:0] even_res, odd_res;
    logic        even_vld, odd_vld, irq;

    typedef struct { logic odd; logic [15:0] val; logic irq; } exp_t;
    exp_t q[$];

    int total = 0, bad = 0;
    int req_cnt, shr_cnt, shr_at, ded_cnt;
    logic first_ch;
    logic [9:0] even_val, odd_val;
    int lat = 0;
    logic cur_odd = 1'b0;

    always #2 clk = ~clk;

    pair_adc_seq uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .hw_trig(hw_trig), .conv_done(conv_done), .conv_data(conv_data),
        .conv_req(conv_req), .conv_ch(conv_ch), .ded_sample(ded_sample),
        .shr_sample(shr_sample), .even_res(even_res), .even_vld(even_vld),
        .odd_res(odd_res), .odd_vld(odd_vld), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] fmt(input logic frac, input logic [9:0] v);
        return frac ? {v, 6'b0} : {6'b0, v};
    endfunction

    // converter model: done three cycles after a request
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                conv_done <= 1'b1;
                conv_data <= cur_odd ? odd_val : even_val;
            end
        end
        if (conv_req) begin
            lat     <= 3;
            cur_odd <= conv_ch;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_req) begin
                req_cnt++;
                if (req_cnt == 1) first_ch = conv_ch;
                if (shr_sample) shr_at = req_cnt;
            end else if (shr_sample) begin
                shr_at = 0;
            end
            if (shr_sample) shr_cnt++;
            if (ded_sample) ded_cnt++;
            if (even_vld || odd_vld) begin
                if (q.size() == 0) begin
                    chk("R11 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R2/R12 result channel", int'(odd_vld), int'(e.odd));
                    chk("R8 result value", int'(odd_vld ? odd_res : even_res), int'(e.val));
                    chk("R7 irq with result", int'(irq), int'(e.irq));
                end
            end else if (irq) begin
                chk("R7 irq without result", 1, 0);
            end
        end
    end

    task automatic wr(input logic [6:0] v);
        @(posedge clk); #1 ctrl_we = 1'b1; ctrl_wdata = v;
        @(posedge clk); #1 ctrl_we = 1'b0;
    endtask

    task automatic run_pair(input logic odd_first, input logic seq, input logic asy,
                            input logic early, input logic frac,
                            input logic [9:0] ev, input logic [9:0] od,
                            input bit use_sw, input bit extra, input bit try_lock);
        logic [6:0] cfg;
        int exp_at;
        cfg = {asy, seq, odd_first, early, frac, 1'b0, 1'b0};
        wr(cfg);
        wr(cfg | 7'd1);
        if (try_lock) wr((cfg ^ 7'b0011100) | 7'd1); // R10: ignored while enabled
        even_val = ev;
        odd_val  = od;
        q.push_back('{odd_first, fmt(frac, odd_first ? od : ev), early});
        q.push_back('{!odd_first, fmt(frac, odd_first ? ev : od), !early});
        req_cnt = 0; shr_cnt = 0; shr_at = -1; ded_cnt = 0;
        if (asy) begin
            @(negedge clk);
            chk("R6 dedicated sampling while idle", int'(ded_sample), 1);
        end
        if (use_sw) begin
            wr(cfg | 7'd3);
        end else begin
            @(posedge clk); #1 hw_trig = 1'b1;
            @(negedge clk);
            if (asy) chk("R6 dedicated stops on trigger", int'(ded_sample), 0);
            @(posedge clk); #1 hw_trig = 1'b0;
        end
        if (extra) begin
            repeat (4) @(posedge clk);
            #1 hw_trig = 1'b1;
            @(posedge clk); #1 hw_trig = 1'b0;
        end
        repeat (25) @(posedge clk);
        chk("R12 all results delivered", q.size(), 0);
        chk("R11 two requests per pair", req_cnt, 2);
        chk("R2 first channel", int'(first_ch), int'(odd_first));
        chk("R3/R4 one shared strobe", shr_cnt, 1);
        exp_at = seq ? (odd_first ? 1 : 2) : 0;
        chk(seq ? "R3 shared strobe position" : "R4 shared strobe position", shr_at, exp_at);
        if (!asy) chk("R5 dedicated window length", ded_cnt, 2);
        if (use_sw) begin
            repeat (20) @(posedge clk);
            chk("R9 held software trigger fires once", req_cnt, 2);
            q.delete();
        end
        wr(cfg);
        q.delete();
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset conv_req", int'(conv_req), 0);
        chk("R1 reset ded_sample", int'(ded_sample), 0);
        chk("R1 reset shr_sample", int'(shr_sample), 0);
        chk("R1 reset irq/valid", int'({irq, even_vld, odd_vld}), 0);
        chk("R1 reset results", int'({even_res, odd_res}), 0);
        req_cnt = 0;
        @(posedge clk); #1 hw_trig = 1'b1;
        @(posedge clk); #1 hw_trig = 1'b0;
        repeat (10) @(posedge clk);
        chk("R1 trigger while off ignored", req_cnt, 0);

        run_pair(0, 0, 0, 0, 0, 10'h2A5, 10'h15A, 0, 0, 0);
        run_pair(1, 0, 0, 1, 1, 10'h3FF, 10'h001, 0, 0, 0);
        run_pair(0, 1, 0, 1, 0, 10'h123, 10'h321, 0, 0, 0);
        run_pair(1, 1, 1, 0, 1, 10'h0F0, 10'h30F, 0, 0, 0);
        run_pair(0, 0, 1, 0, 0, 10'h200, 10'h1FF, 0, 1, 0);
        run_pair(0, 1, 0, 0, 0, 10'h0AA, 10'h355, 1, 0, 0);
        run_pair(0, 0, 0, 0, 0, 10'h111, 10'h222, 0, 1, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule